// File: doc/BRIEF.md
# Strided Vector Load Address Generator

This block produces the request stream for a single strided vector load on a byte-addressable memory. Before a load, software supplies three values: a starting byte address, a byte increment, and an element count. A one-cycle start pulse latches all three. The block then emits one memory request per vector element. Each request carries the element's byte address and its slot number in the destination vector register. The slot number tells the downstream logic where the returned data belongs.

The byte increment covers two things at once: how far apart the elements sit and how many bytes each element occupies. For a row of a column-major matrix with 32-bit entries and three rows, the increment is 12. For a column of that matrix it is 4. With one-byte entries and the same layout, the row increment would be 3. The element count is programmed separately, so the same logic walks rows and columns of any shape. The block fetches no data and writes no registers. It only generates addresses and slot tags.

Requests leave over a valid/ready handshake. Once `req_valid_o` is high, the address and slot stay unchanged until the consumer raises `req_ready_i`. A request moves on only on a cycle where both are high. The consumer may hold ready low for any number of cycles, and nothing is dropped or repeated. `busy_o` and `done_o` are plain level and pulse pins.

Top module: `svec_addr_gen`

## Requirements
- R1: Base address, byte increment and element count are sampled on the clock edge that accepts start. Changes to those inputs afterwards have no effect on the operation in progress.
- R2: After an accepted start with a non-zero count, `req_valid_o` is high on the next cycle, with `req_addr_o` equal to the sampled base and `req_idx_o` equal to 0.
- R3: Every request after the first has an address equal to the previous request's address plus the sampled increment, taken modulo 2^ADDR_W. Examples: base 1 / increment 12 / count 5 gives 1,13,25,37,49; base 25 / increment 4 / count 3 gives 25,29,33; base 1 / increment 3 / count 5 gives 1,4,7,10,13.
- R4: Requests carry slot numbers 0,1,…,count-1 in order, and exactly count requests are accepted per operation.
- R5: While `req_valid_o` is high and `req_ready_i` is low, address and slot stay stable and valid stays high. They advance only on a cycle where valid and ready are both high.
- R6: `done_o` is high for exactly one cycle: the cycle after the last request is accepted. In that same cycle `busy_o` and `req_valid_o` are low.
- R7: A start with count 0 issues no request. It raises `done_o` for one cycle on the cycle after start, and `busy_o` stays low.
- R8: A start pulse while `busy_o` is high is ignored. The running sequence continues unchanged and no new operation begins.
- R9: `busy_o` is high from the cycle after an accepted non-zero start until the last request is accepted, and it equals `req_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a load; ignored while busy |
| base_i | input | ADDR_W | Byte address of element 0 |
| stride_i | input | ADDR_W | Byte increment between consecutive elements |
| len_i | input | LEN_W | Number of elements to request |
| req_valid_o | output | 1 | A request is offered |
| req_ready_i | input | 1 | Consumer accepts the offered request |
| req_addr_o | output | ADDR_W | Byte address of the offered request |
| req_idx_o | output | LEN_W | Destination slot of the offered request |
| busy_o | output | 1 | An operation is issuing requests |
| done_o | output | 1 | One-cycle pulse when an operation ends |

## Verification
A corrupted address accumulator appears at the ports on the first request after the bad update. That request has a byte address that no longer matches base plus slot times increment. A miscounting slot counter shows up in two ways. The slot number on the very next offered request is wrong. Also, `done_o` fires one or more handshakes too early or too late against the programmed count. A control state that ignores back-pressure or re-accepts start shows up within one cycle, as an address that moves while ready is low or a sequence that restarts from a new base.

// File: rtl/svag_pkg.sv
package svag_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } svag_state_e;
endpackage

// File: rtl/svag_cfg_latch.sv
// Holds the byte increment and element count for the running operation.
module svag_cfg_latch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] stride_q,
  output logic [LEN_W-1:0]  len_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      len_q    <= '0;
    end else if (load_i) begin
      stride_q <= stride_i;
      len_q    <= len_i;
    end
  end
endmodule

// File: rtl/svag_addr_step.sv
// Byte address accumulator: loads the base, then adds the increment per handshake.
module svag_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] stride_q,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] sum;

  // Modulo 2^ADDR_W wrap is the natural carry-out drop.
  assign sum = addr_o + stride_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (adv_i)  addr_o <= sum;
  end
endmodule

// File: rtl/svag_elem_cnt.sv
// Destination slot counter with final-element detection.
module svag_elem_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  assign last_o = (idx_o == (len_q - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (load_i) idx_o <= '0;
    else if (adv_i)  idx_o <= idx_o + ONE;
  end
endmodule

// File: rtl/svag_ctrl.sv
// Sequencer: accepts start when idle, ends on the final handshake.
module svag_ctrl
  import svag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic fire_i,
  input  logic last_i,
  output logic load_o,
  output logic adv_o,
  output logic busy_o,
  output logic done_o
);
  svag_state_e state_q, state_d;
  logic        done_d;

  assign busy_o = (state_q == ST_ISSUE);
  assign load_o = start_i && (state_q == ST_IDLE);
  assign adv_o  = fire_i && !last_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (len_zero_i) done_d  = 1'b1;
          else            state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (fire_i && last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end
endmodule

// File: rtl/svec_addr_gen.sv
module svec_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              load;
  logic              adv;
  logic              fire;
  logic              last;
  logic              len_zero;
  logic [ADDR_W-1:0] stride_q;
  logic [LEN_W-1:0]  len_q;

  assign len_zero    = (len_i == '0);
  assign fire        = busy_o && req_ready_i;
  assign req_valid_o = busy_o;

  svag_cfg_latch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .stride_i (stride_i),
    .len_i    (len_i),
    .stride_q (stride_q),
    .len_q    (len_q)
  );

  svag_addr_step #(.ADDR_W(ADDR_W)) addr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .base_i   (base_i),
    .adv_i    (adv),
    .stride_q (stride_q),
    .addr_o   (req_addr_o)
  );

  svag_elem_cnt #(.LEN_W(LEN_W)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .adv_i  (adv),
    .len_q  (len_q),
    .idx_o  (req_idx_o),
    .last_o (last)
  );

  svag_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_zero_i (len_zero),
    .fire_i     (fire),
    .last_i     (last),
    .load_o     (load),
    .adv_o      (adv),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/svec_addr_gen_chk.sv
module svec_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_idx_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] stride_q,
  input logic [LEN_W-1:0]  len_q
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  AST_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (len_i != '0) |=> req_valid_o && (req_addr_o == $past(base_i)) && (req_idx_o == '0)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> !req_valid_o || (req_addr_o == $past(req_addr_o) + stride_q)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> !req_valid_o || (req_idx_o == $past(req_idx_o) + ONE)); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_idx_o < len_q)); // R4

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_idx_o)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !req_valid_o); // R6

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (len_i == '0) |=> done_o && !busy_o); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(stride_q) && $stable(len_q)); // R8

  AST_BUSY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == req_valid_o); // R9
endmodule

bind svec_addr_gen svec_addr_gen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .base_i      (base_i),
  .len_i       (len_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_idx_o   (req_idx_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .stride_q    (stride_q),
  .len_q       (len_q)
);

// File: tb/svec_addr_gen_tb_top.sv
module svec_addr_gen_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [ADDR_W-1:0] stride_i = '0;
  logic [LEN_W-1:0]  len_i = '0;
  logic              req_ready_i = 1'b0;
  logic              req_valid_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [LEN_W-1:0]  req_idx_o;
  logic              busy_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  svec_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .len_i(len_i), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_idx_o(req_idx_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // {base, increment, count, ready pattern (0 always, 1 every other cycle), poke start}
  localparam int NV = 7;
  localparam logic [87:0] VECS [NV] = '{
    {32'd1,          32'd12,         8'd5, 8'd0, 8'd0},  // R3 row walk 1,13,25,37,49
    {32'd25,         32'd4,          8'd3, 8'd1, 8'd0},  // R3 column walk 25,29,33
    {32'd1,          32'd3,          8'd5, 8'd0, 8'd1},  // R3 byte entries 1,4,7,10,13; R8 poke
    {32'hFFFF_FFF8,  32'd8,          8'd4, 8'd1, 8'd0},  // R3 wrap past top
    {32'd100,        32'hFFFF_FFFC,  8'd3, 8'd0, 8'd0},  // R3 negative increment
    {32'd7,          32'd0,          8'd2, 8'd1, 8'd1},  // zero increment
    {32'h4000,       32'd16,         8'd1, 8'd1, 8'd0}   // single element
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] base, input logic [31:0] stride,
                        input logic [7:0] len, input logic [7:0] mode, input logic [7:0] poke);
    logic [31:0] exp_addr;
    int n;
    bit tog;
    bit rdy;
    @(negedge clk);
    base_i = base; stride_i = stride; len_i = len; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R1: disturb inputs after capture
    base_i = ~base; stride_i = stride + 32'd5; len_i = len + 8'd3;
    exp_addr = base; n = 0; tog = 1'b0;
    while (n < int'(len)) begin
      chk("R9", "valid while issuing", {63'd0, req_valid_o}, 64'd1);
      chk("R9", "busy while issuing", {63'd0, busy_o}, 64'd1);
      chk("R6", "no done while issuing", {63'd0, done_o}, 64'd0);
      chk(n == 0 ? "R2" : "R3", "address", {32'd0, req_addr_o}, {32'd0, exp_addr});
      chk("R4", "slot", {56'd0, req_idx_o}, n);
      rdy = (mode == 8'd0) ? 1'b1 : tog;
      tog = ~tog;
      req_ready_i = rdy;
      start_i = (poke != 8'd0) && (n == 1);  // R8
      if (start_i) begin base_i = 32'hDEAD_0000; stride_i = 32'd1; len_i = 8'd9; end
      @(negedge clk);
      start_i = 1'b0;
      if (rdy) begin exp_addr = exp_addr + stride; n++; end
      else chk("R5", "stall keeps address", {32'd0, req_addr_o}, {32'd0, exp_addr});
    end
    req_ready_i = 1'b0;
    chk("R6", "done after last accept", {63'd0, done_o}, 64'd1);
    chk("R6", "valid low at done", {63'd0, req_valid_o}, 64'd0);
    chk("R6", "busy low at done", {63'd0, busy_o}, 64'd0);
    @(negedge clk);
    chk("R6", "done single cycle", {63'd0, done_o}, 64'd0);
    chk("R4", "no extra request", {63'd0, req_valid_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset valid", {63'd0, req_valid_o}, 64'd0);
    chk("R9", "reset busy", {63'd0, busy_o}, 64'd0);
    chk("R6", "reset done", {63'd0, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v][87:56], VECS[v][55:24], VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]);
    end

    // R7: zero count
    @(negedge clk);
    base_i = 32'h10; stride_i = 32'd4; len_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; req_ready_i = 1'b1;
    chk("R7", "done after zero start", {63'd0, done_o}, 64'd1);
    chk("R7", "no request", {63'd0, req_valid_o}, 64'd0);
    chk("R7", "not busy", {63'd0, busy_o}, 64'd0);
    @(negedge clk);
    chk("R7", "done single cycle", {63'd0, done_o}, 64'd0);
    chk("R7", "still no request", {63'd0, req_valid_o}, 64'd0);
    req_ready_i = 1'b0;

    // R5: long stall then release
    @(negedge clk);
    base_i = 32'h200; stride_i = 32'd8; len_i = 8'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5", "held address", {32'd0, req_addr_o}, 64'h200);
    chk("R5", "held slot", {56'd0, req_idx_o}, 64'd0);
    chk("R5", "held valid", {63'd0, req_valid_o}, 64'd1);
    req_ready_i = 1'b1;
    @(negedge clk);
    chk("R3", "advance after accept", {32'd0, req_addr_o}, 64'h208);
    chk("R4", "slot after accept", {56'd0, req_idx_o}, 64'd1);
    @(negedge clk);
    req_ready_i = 1'b0;
    chk("R6", "done after pair", {63'd0, done_o}, 64'd1);
    @(negedge clk);

    // R1: repeat of first vector with different live inputs gives same first address
    run_op(32'd1, 32'd12, 8'd5, 8'd1, 8'd1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule